// File: doc/BRIEF.md
# Daisy-Chained Shift-Register Port Expander

This controller widens a chip's I/O by driving two external daisy chains of 8-bit shift registers over one shared serial clock. One chain captures parallel inputs and hands them back serially. The other takes serial data and updates its parallel outputs only when a latch pulse arrives. A single frame loads the input chain once, then swaps one to four bytes in both directions at the same time, one bit per serial clock. It finishes with one latch pulse, so every output pin changes at once.

A frame is requested over a valid/ready pair. The request is taken in a cycle where `start_valid` and `start_ready` are both high. `start_ready` is high only while the controller is idle. A requester that holds `start_valid` during a frame is back-pressured and waits; it is taken in the first idle cycle, which is the cycle `done` is high. `num_bytes` and `tick_div` are sampled at acceptance. `out_bytes` is read at each byte boundary, so it must stay stable until `done`. Byte k (1-based) occupies bits [8k-1:8k-8] of both `out_bytes` and `in_bytes`.

Every pin step lasts one tick of T+1 system clocks, where T is `tick_div` raised to at least 1. The serial input passes through a two-flop synchroniser. It is sampled one full tick after the serial clock falls.

Top module: `chain_io_expander`

## Requirements
- R1: Synchronous reset drives `sr_sclk` low, `sr_load_n` high, `sr_latch` low and `sr_sdo` low. It clears `in_bytes`, leaves `busy` and `done` low and raises `start_ready`.
- R2: A frame starts only in a cycle with `start_valid` and `start_ready` both high. `busy` is high and `start_ready` low for the whole frame. A `start_valid` pulse during a frame starts nothing.
- R3: Each frame opens with exactly one load sequence. `sr_load_n` falls, `sr_sclk` rises while `sr_load_n` is low, `sr_load_n` rises, then `sr_sclk` falls. `sr_load_n` never falls again within the frame.
- R4: The byte count N is taken from `num_bytes` at acceptance. A value of 0 acts as 1, a value above 4 acts as 4, and a later change has no effect on the running frame.
- R5: Output bytes leave highest index first, from byte N down to byte 1, each least significant bit first. `sr_sdo` never changes while `sr_sclk` is high.
- R6: Each bit read from `sr_sdi` enters the top of a right-shifting byte, so the first bit read ends in bit 0. The byte read while index k is current is stored at index k. Indices above N keep their previous value.
- R7: A frame gives exactly 1+8N rising edges on `sr_sclk`: one during the load and eight per byte.
- R8: After the last bit, `sr_latch` pulses high exactly once per frame. It is never high together with `sr_sclk` or while `sr_load_n` is low.
- R9: `done` is a one-cycle pulse in the cycle after `sr_latch` falls, and `busy` falls at the same edge. From the accepting edge to the rise of `done` there are (4+16N)(T+1) cycles.
- R10: A `tick_div` of 0 is treated as 1, so no tick is shorter than two system clocks.
- R11: With `start_valid` held high across the end of a frame, the next frame is accepted in the `done` cycle. Its `sr_load_n` falls at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_div | input | 8 | Tick length minus one, in system clocks |
| num_bytes | input | 3 | Bytes per frame, sampled at acceptance |
| out_bytes | input | 32 | Byte k to send, bits [8k-1:8k-8] |
| start_valid | input | 1 | Frame request |
| start_ready | output | 1 | High while idle; request taken when both are high |
| busy | output | 1 | High for the whole frame |
| done | output | 1 | One-cycle end-of-frame pulse |
| in_bytes | output | 32 | Captured byte k, bits [8k-1:8k-8] |
| sr_sclk | output | 1 | Shared serial clock to both chains |
| sr_load_n | output | 1 | Parallel load of the input chain, active low |
| sr_sdo | output | 1 | Serial data to the output chain |
| sr_sdi | input | 1 | Serial data from the input chain |
| sr_latch | output | 1 | Output chain latch pulse |

## Verification
The end of one frame and the acceptance of the next can fall in the same cycle. The `done` pulse and the idle `start_ready` coincide, and a held request is taken right there. The bench provokes this by keeping `start_valid` high through a whole frame. At the `done` sample it expects `start_ready` high and `busy` low. One cycle later it expects `busy` high and `sr_load_n` low. The second frame must then repeat its load, bit count, latch and captured data exactly as a frame started from a quiet idle would. A second clash, a request arriving mid-frame, is judged by counting load sequences and latch pulses at the pins.

// File: rtl/chxp_pkg.sv
package chxp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LDLO,   // load low, clock low
    S_LDCK,   // load low, clock high
    S_LDREL,  // load released, clock high
    S_SETUP,  // data presented, input sampled at end
    S_PULSE,  // serial clock high
    S_STRB    // latch pulse
  } seq_state_e;
endpackage

// File: rtl/chxp_tick.sv
module chxp_tick #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [PRESC_W-1:0] div,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R10: divider is floored at 1, so ticks never come back to back
  p_tick_spacing_r10: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/chxp_sync.sv
module chxp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/chxp_seq.sv
module chxp_seq
  import chxp_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  localparam int CNT_W = $clog2(MAX_BYTES + 1),
  localparam int BUS_W = BYTE_W * MAX_BYTES,
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start_valid,
  input  logic [CNT_W-1:0] nbytes,
  input  logic [BUS_W-1:0] out_bytes,
  input  logic             din,
  output logic             start_ready,
  output logic             busy,
  output logic             done,
  output logic [BUS_W-1:0] in_bytes,
  output logic             sclk,
  output logic             load_n,
  output logic             dout,
  output logic             latch
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  idx_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] in_q [MAX_BYTES];

  function automatic logic [BYTE_W-1:0] pick(input logic [BUS_W-1:0] bus,
                                             input logic [CNT_W-1:0] k);
    pick = '0;
    for (int j = 0; j < MAX_BYTES; j++)
      if (k == CNT_W'(j + 1)) pick = bus[j*BYTE_W +: BYTE_W];
  endfunction

  assign start_ready = (st_q == S_IDLE);
  assign busy        = (st_q != S_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (start_valid) st_d = S_LDLO;
      S_LDLO:  if (tick) st_d = S_LDCK;
      S_LDCK:  if (tick) st_d = S_LDREL;
      S_LDREL: if (tick) st_d = S_SETUP;
      S_SETUP: if (tick) st_d = S_PULSE;
      S_PULSE: if (tick) st_d = (bit_q == BIT_LAST && idx_q == CNT_W'(1)) ? S_STRB : S_SETUP;
      S_STRB:  if (tick) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      dout   <= 1'b0;
      sclk   <= 1'b0;
      load_n <= 1'b1;
      latch  <= 1'b0;
      done   <= 1'b0;
      for (int j = 0; j < MAX_BYTES; j++) in_q[j] <= '0;
    end else begin
      st_q   <= st_d;
      sclk   <= (st_d == S_LDCK) || (st_d == S_LDREL) || (st_d == S_PULSE);
      load_n <= !((st_d == S_LDLO) || (st_d == S_LDCK));
      latch  <= (st_d == S_STRB);
      done   <= (st_q == S_STRB) && tick;
      case (st_q)
        S_IDLE: if (start_valid) begin
          idx_q <= nbytes;
          bit_q <= '0;
          sh_q  <= pick(out_bytes, nbytes);
        end
        S_LDREL: if (tick) dout <= sh_q[0];
        S_SETUP: if (tick) sh_q <= {din, sh_q[BYTE_W-1:1]};
        S_PULSE: if (tick) begin
          bit_q <= bit_q + 1'b1;
          if (bit_q == BIT_LAST) begin
            for (int j = 0; j < MAX_BYTES; j++)
              if (idx_q == CNT_W'(j + 1)) in_q[j] <= sh_q;
            if (idx_q != CNT_W'(1)) begin
              idx_q <= idx_q - CNT_W'(1);
              sh_q  <= pick(out_bytes, idx_q - CNT_W'(1));
              dout  <= pick(out_bytes, idx_q - CNT_W'(1))[0];
            end
          end else begin
            dout <= sh_q[0];
          end
        end
        S_STRB: if (tick) dout <= 1'b0;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_in
    assign in_bytes[g*BYTE_W +: BYTE_W] = in_q[g];
  end

  // R5: output data holds while the serial clock is high
  p_sdo_steady_r5: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(dout));
  // R8: latch never overlaps the serial clock or the load
  p_latch_alone_r8: assert property (@(posedge clk) disable iff (rst)
    latch |-> (load_n && !sclk));
  // R3: load only begins from idle
  p_load_at_start_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(load_n) |-> $past(st_q == S_IDLE));
  // R9: done follows the latch pulse and closes the frame
  p_done_after_latch_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(latch) && !latch && !busy));
  // R9: done lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/chain_io_expander.sv
module chain_io_expander
  import chxp_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int PRESC_W   = 8,
  localparam int CNT_W = $clog2(MAX_BYTES + 1),
  localparam int BUS_W = BYTE_W * MAX_BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PRESC_W-1:0] tick_div,
  input  logic [CNT_W-1:0]   num_bytes,
  input  logic [BUS_W-1:0]   out_bytes,
  input  logic               start_valid,
  output logic               start_ready,
  output logic               busy,
  output logic               done,
  output logic [BUS_W-1:0]   in_bytes,
  output logic               sr_sclk,
  output logic               sr_load_n,
  output logic               sr_sdo,
  input  logic               sr_sdi,
  output logic               sr_latch
);
  logic               accept, tick, sdi_s;
  logic [PRESC_W-1:0] div_q;
  logic [CNT_W-1:0]   n_eff;

  assign accept = start_valid && start_ready;

  always_comb begin
    if (num_bytes == '0)                     n_eff = CNT_W'(1);
    else if (num_bytes > CNT_W'(MAX_BYTES))  n_eff = CNT_W'(MAX_BYTES);
    else                                     n_eff = num_bytes;
  end

  always_ff @(posedge clk) begin
    if (rst)         div_q <= PRESC_W'(1);
    else if (accept) div_q <= (tick_div == '0) ? PRESC_W'(1) : tick_div;
  end

  chxp_tick #(.PRESC_W(PRESC_W)) u_tick (
    .clk(clk), .rst(rst), .run(busy), .div(div_q), .tick(tick)
  );

  chxp_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(sr_sdi), .q(sdi_s)
  );

  chxp_seq #(.MAX_BYTES(MAX_BYTES)) u_seq (
    .clk(clk), .rst(rst), .tick(tick),
    .start_valid(start_valid), .nbytes(n_eff), .out_bytes(out_bytes),
    .din(sdi_s), .start_ready(start_ready), .busy(busy), .done(done),
    .in_bytes(in_bytes), .sclk(sr_sclk), .load_n(sr_load_n),
    .dout(sr_sdo), .latch(sr_latch)
  );
endmodule

// File: tb/tb_chain_io_expander.sv
module tb_chain_io_expander;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  tick_div = 8'd1;
  logic [2:0]  num_bytes = 3'd1;
  logic [31:0] out_bytes = '0;
  logic        start_valid = 1'b0;
  logic        start_ready, busy, done, sr_sclk, sr_load_n, sr_sdo, sr_sdi, sr_latch;
  logic [31:0] in_bytes;

  chain_io_expander dut (
    .clk(clk), .rst(rst), .tick_div(tick_div), .num_bytes(num_bytes),
    .out_bytes(out_bytes), .start_valid(start_valid), .start_ready(start_ready),
    .busy(busy), .done(done), .in_bytes(in_bytes), .sr_sclk(sr_sclk),
    .sr_load_n(sr_load_n), .sr_sdo(sr_sdo), .sr_sdi(sr_sdi), .sr_latch(sr_latch)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // external chain models, sampled on the falling system edge
  logic [31:0] src_chain = '0, piso = '0, sipo = '0, latched = '0;
  logic        p_sclk = 1'b0, p_ld = 1'b1, p_lat = 1'b0;
  int          rise_cnt = 0, rise_ld = 0, ldfall = 0, lat_cnt = 0;
  logic [7:0]  ext_in [1:4];

  assign sr_sdi = piso[0];

  always @(negedge clk) begin
    p_sclk <= sr_sclk;
    p_ld   <= sr_load_n;
    p_lat  <= sr_latch;
    if (!sr_load_n) piso <= src_chain;
    else if (sr_sclk && !p_sclk) piso <= {1'b0, piso[31:1]};
    if (sr_sclk && !p_sclk) begin
      rise_cnt <= rise_cnt + 1;
      sipo <= {sr_sdo, sipo[31:1]};
      if (!sr_load_n) rise_ld <= rise_ld + 1;
    end
    if (!sr_load_n && p_ld) ldfall <= ldfall + 1;
    if (sr_latch && !p_lat) begin
      lat_cnt <= lat_cnt + 1;
      latched <= sipo;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 150000) begin
      n_chk = n_chk + 1;
      n_err = n_err + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int b_rise, b_rld, b_ldf, b_lat;
  logic [31:0] prev_in;

  task automatic snap();
    b_rise = rise_cnt; b_rld = rise_ld; b_ldf = ldfall; b_lat = lat_cnt;
    prev_in = in_bytes;
  endtask

  task automatic prepare(input int neff, input int seed);
    for (int k = 1; k <= 4; k++) begin
      out_bytes[8*(k-1) +: 8] = 8'((seed * 37 + k * 59 + 11) ^ (k << 5));
      ext_in[k] = 8'((seed * 91 + k * 23 + 5) ^ 8'h5A);
    end
    src_chain = 32'hC3C3_C3C3;
    for (int k = 1; k <= neff; k++) src_chain[8*(neff-k) +: 8] = ext_in[k];
  endtask

  function automatic int eff_n(input int nreq);
    if (nreq == 0) return 1;
    if (nreq > 4) return 4;
    return nreq;
  endfunction

  function automatic int tick_len(input int div);
    return ((div == 0) ? 1 : div) + 1;
  endfunction

  // drives the request at a falling edge; it is taken at the next rising edge
  task automatic launch(input int nreq, input int div);
    @(negedge clk);
    num_bytes = 3'(nreq);
    tick_div = 8'(div);
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  task automatic await_done(input int poke, output int cyc);
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (poke != 0 && cyc == 20) begin
        start_valid = 1'b1;
        num_bytes = 3'd3;
      end
      if (poke != 0 && cyc == 21) start_valid = 1'b0;
    end
  endtask

  task automatic verify(input int neff, input int div, input int cyc);
    chk("R9", "frame length", 64'(cyc), 64'((4 + 16 * neff) * tick_len(div) + 1));
    chk("R9", "busy low at done", 64'(busy), 64'd0);
    chk("R7", "serial clock edges", 64'(rise_cnt - b_rise), 64'(1 + 8 * neff));
    chk("R3", "edges during load", 64'(rise_ld - b_rld), 64'd1);
    chk("R3", "load sequences", 64'(ldfall - b_ldf), 64'd1);
    chk("R8", "latch pulses", 64'(lat_cnt - b_lat), 64'd1);
    for (int k = 1; k <= 4; k++) begin
      if (k <= neff) begin
        chk("R5", $sformatf("latched byte %0d", k),
            64'(latched[32-8*k +: 8]), 64'(out_bytes[8*(k-1) +: 8]));
        chk("R6", $sformatf("captured byte %0d", k),
            64'(in_bytes[8*(k-1) +: 8]), 64'(ext_in[k]));
      end else begin
        chk("R6", $sformatf("untouched byte %0d", k),
            64'(in_bytes[8*(k-1) +: 8]), 64'(prev_in[8*(k-1) +: 8]));
      end
    end
  endtask

  task automatic one_frame(input int nreq, input int div, input int seed, input int poke);
    int cyc;
    int neff = eff_n(nreq);
    prepare(neff, seed);
    snap();
    launch(nreq, div);
    chk("R2", "busy after accept", 64'({busy, start_ready}), 64'b10);
    await_done(poke, cyc);
    verify(neff, div, cyc);
    @(negedge clk);
    chk("R9", "done one cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "pins after reset", 64'({sr_sclk, sr_load_n, sr_latch, sr_sdo}), 64'b0100);
    chk("R1", "handshake after reset", 64'({busy, start_ready, done}), 64'b010);
    chk("R1", "inputs cleared", 64'(in_bytes), 64'd0);
  endtask

  task automatic t_two_bytes();   one_frame(2, 3, 1, 0); endtask
  task automatic t_four_bytes();  one_frame(4, 1, 2, 0); endtask
  task automatic t_one_byte();    one_frame(1, 2, 3, 0); endtask
  task automatic t_count_zero();  one_frame(0, 1, 4, 0); endtask // R4 floor
  task automatic t_count_high();  one_frame(7, 1, 5, 0); endtask // R4 ceiling
  task automatic t_div_zero();    one_frame(3, 0, 6, 0); endtask // R10

  task automatic t_busy_poke();
    one_frame(1, 1, 7, 1);
    snap();
    repeat (10) @(negedge clk);
    chk("R2", "no frame from mid-frame request", 64'(ldfall - b_ldf), 64'd0);
    chk("R2", "idle after poke", 64'({busy, start_ready}), 64'b01);
  endtask

  task automatic t_back_to_back();
    int cyc;
    prepare(2, 8);
    snap();
    @(negedge clk);
    num_bytes = 3'd2; tick_div = 8'd1; start_valid = 1'b1;
    @(negedge clk);
    await_done(0, cyc);
    verify(2, 1, cyc);
    chk("R11", "ready in done cycle", 64'({done, start_ready, busy}), 64'b110);
    prepare(1, 9);
    num_bytes = 3'd1;
    snap();
    @(negedge clk);
    chk("R11", "second frame taken", 64'({busy, sr_load_n, done}), 64'b100);
    start_valid = 1'b0;
    await_done(0, cyc);
    verify(1, 1, cyc);
    @(negedge clk);
  endtask

  task automatic t_reset_again();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "inputs cleared by reset", 64'(in_bytes), 64'd0);
    chk("R1", "pins idle after reset", 64'({sr_sclk, sr_load_n, sr_latch, sr_sdo}), 64'b0100);
  endtask

  initial begin
    t_reset();
    t_two_bytes();
    t_four_bytes();
    t_one_byte();
    t_count_zero();
    t_count_high();
    t_div_zero();
    t_busy_poke();
    t_back_to_back();
    t_reset_again();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule